// File: doc/BRIEF.md
# H-Bridge Gate Sequencer

This block sits between a motor controller and the gate drivers of a two-leg H-bridge. Each leg has one high-side and one low-side switch. The block takes a direction bit, an enable bit and two decay-select bits, and produces four gate-enable lines. When enable is high the bridge drives the load. When enable is low the block selects a decay state: fast decay, which reverses the legs, or slow decay, which closes both low-side or both high-side switches. The control inputs may carry PWM at up to 100 kHz, and a permanent 100 % enable is a valid command.

All control inputs are asynchronous, so each one passes through a synchronizer first. Each leg goes through a dead interval before any of its switches closes. During that interval both switches of the leg are open. In fast decay a zero-current flag from an external comparator opens the whole bridge, and the bridge stays open until the next drive command. Two conditions hold every gate off:

- the sleep input is low, or
- a settling interval after wake-up has not yet run out.

A force-off line from a fault supervisor opens every gate in the same cycle. After force-off is released, control returns through the normal dead interval.

Top module: `hbridge_gate_ctl`

Gate codes are written {A high, A low, B high, B low}, where 1 means the switch is closed. Latency means edges after an input is first sampled; with SYNC_STAGES synchronizer flops, a state change reaches the gates at edge SYNC_STAGES+1 when the leg is already open and has finished its dead interval.

## Requirements
- R1: While the sleep input is low, all four gates are 0 within SYNC_STAGES+1 cycles, whatever the other inputs do.
- R2: With enable high and direction 1 the gates settle to 1001; with direction 0 they settle to 0110. Both mode bits are ignored. Enable held high indefinitely keeps the drive state.
- R3: With enable low and mode1 low (fast decay), direction 0 gives 1001 and direction 1 gives 0110.
- R4: With enable low and mode1 high, mode2 low gives 0101 and mode2 high gives 1010. Direction is ignored in both cases.
- R5: In fast decay a synchronized zero-current flag opens all four gates. They stay 0 in fast decay after the flag drops, until enable is next sampled high. Slow decay is still obeyed while this hold is set.
- R6: Each leg has both gates at 0 for at least DEAD_CYC consecutive cycles before either of its gates turns on after the leg was switched off.
- R7: The high-side and low-side gates of one leg are never 1 together.
- R8: After the synchronized sleep input rises (or reset ends with sleep high), all gates stay 0 for WAKE_CYC cycles. Drive begins on the following edge.
- R9: Force-off high opens all four gates in the same cycle, without waiting for a clock edge. After release, each leg stays open for DEAD_CYC cycles before it follows the command.
- R10: During reset, and before the first wake-up interval has run out, all gates are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep_n_i | input | 1 | Low puts the bridge to sleep (asynchronous) |
| dir_i | input | 1 | Direction command (asynchronous) |
| en_i | input | 1 | Drive enable, may carry PWM (asynchronous) |
| mode1_i | input | 1 | 0 selects fast decay, 1 selects slow decay (asynchronous) |
| mode2_i | input | 1 | Slow decay path: 0 low side, 1 high side (asynchronous) |
| zero_i | input | 1 | Zero-current flag from the current comparator (asynchronous) |
| force_off_i | input | 1 | Fault supervisor force-off, acts on the gates combinationally |
| gate_ah_o | output | 1 | Leg A high-side gate enable |
| gate_al_o | output | 1 | Leg A low-side gate enable |
| gate_bh_o | output | 1 | Leg B high-side gate enable |
| gate_bl_o | output | 1 | Leg B low-side gate enable |

## Verification
The decode is first tried with every static combination of enable, direction and mode bits. This shows that the don't-care inputs (mode bits while driving, direction in slow decay) really are ignored. Transitions that flip both legs at once, and transitions that flip only one leg, show apart the dead-interval path from the stay-on path. A PWM burst on enable, with slow decay in the off phase, exercises repeated dead intervals back to back. A zero-flag pulse followed by slow decay and then a new drive command shows apart the hold, its bypass and its clearing. Sleep, wake and force-off pulses, each applied from a driving state, expose the exact cycle in which the gates open and close again.

// File: rtl/hbg_pkg.sv
package hbg_pkg;

  typedef enum logic [1:0] {
    LEG_OFF = 2'd0,
    LEG_HI  = 2'd1,
    LEG_LO  = 2'd2
  } leg_t;

  typedef struct packed {
    leg_t a;
    leg_t b;
  } bridge_t;

  // bit positions inside the synchronized control vector
  localparam int CTL_SLEEP = 0;
  localparam int CTL_DIR   = 1;
  localparam int CTL_EN    = 2;
  localparam int CTL_M1    = 3;
  localparam int CTL_M2    = 4;
  localparam int CTL_ZERO  = 5;
  localparam int CTL_W     = 6;

  // {high gate, low gate} for one leg state
  function automatic logic [1:0] leg_gates(leg_t s);
    return {s == LEG_HI, s == LEG_LO};
  endfunction

  // command decode: drive, fast decay, slow decay
  function automatic bridge_t decode_cmd(logic ready, logic en, logic dir,
                                         logic m1, logic m2, logic hold_off);
    bridge_t r;
    if (!ready) begin
      r.a = LEG_OFF; r.b = LEG_OFF;
    end else if (en) begin
      r.a = dir ? LEG_HI : LEG_LO;
      r.b = dir ? LEG_LO : LEG_HI;
    end else if (!m1) begin
      if (hold_off) begin
        r.a = LEG_OFF; r.b = LEG_OFF;
      end else begin
        r.a = dir ? LEG_LO : LEG_HI;
        r.b = dir ? LEG_HI : LEG_LO;
      end
    end else begin
      r.a = m2 ? LEG_HI : LEG_LO;
      r.b = r.a;
    end
    return r;
  endfunction

endpackage

// File: rtl/hbg_sync.sv
module hbg_sync #(
  parameter int WIDTH  = 6,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] pipe [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) pipe[i] <= '0;
    end else begin
      pipe[0] <= d_i;
      for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
    end
  end

  assign q_o = pipe[STAGES-1];
endmodule

// File: rtl/hbg_cmd.sv
module hbg_cmd
  import hbg_pkg::*;
#(
  parameter int WAKE_CYC = 100000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CTL_W-1:0]  ctl_i,
  output bridge_t           tgt_o,
  output logic              ready_o,
  output logic              zero_hold_o
);
  localparam int WW = $clog2(WAKE_CYC + 1);

  logic [WW-1:0] wake_cnt;
  logic          sleep_s, dir_s, en_s, m1_s, m2_s, zero_s;
  logic          in_fast;

  assign sleep_s = ctl_i[CTL_SLEEP];
  assign dir_s   = ctl_i[CTL_DIR];
  assign en_s    = ctl_i[CTL_EN];
  assign m1_s    = ctl_i[CTL_M1];
  assign m2_s    = ctl_i[CTL_M2];
  assign zero_s  = ctl_i[CTL_ZERO];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 wake_cnt <= WW'(WAKE_CYC);
    else if (!sleep_s)          wake_cnt <= WW'(WAKE_CYC);
    else if (wake_cnt != '0)    wake_cnt <= wake_cnt - 1'b1;
  end

  assign ready_o = sleep_s && (wake_cnt == '0);
  assign in_fast = ready_o && !en_s && !m1_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  zero_hold_o <= 1'b0;
    else if (en_s)               zero_hold_o <= 1'b0;
    else if (in_fast && zero_s)  zero_hold_o <= 1'b1;
  end

  assign tgt_o = decode_cmd(ready_o, en_s, dir_s, m1_s, m2_s,
                            zero_hold_o || zero_s);
endmodule

// File: rtl/hbg_leg.sv
module hbg_leg
  import hbg_pkg::*;
#(
  parameter int DEAD_CYC = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  leg_t tgt_i,
  input  logic force_off_i,
  output logic gate_hi_o,
  output logic gate_lo_o,
  output logic dead_done_o
);
  localparam int CW = $clog2(DEAD_CYC + 1);
  localparam logic [CW-1:0] LOAD = CW'(DEAD_CYC - 1);

  leg_t          cur;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur <= LEG_OFF;
      cnt <= LOAD;
    end else if (force_off_i) begin
      cur <= LEG_OFF;
      cnt <= LOAD;
    end else if (cur != LEG_OFF) begin
      if (cur != tgt_i) begin
        cur <= LEG_OFF;
        cnt <= LOAD;
      end
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end else if (tgt_i != LEG_OFF) begin
      cur <= tgt_i;
    end
  end

  assign dead_done_o = (cur == LEG_OFF) && (cnt == '0);
  assign {gate_hi_o, gate_lo_o} = leg_gates(cur) & {2{!force_off_i}};
endmodule

// File: rtl/hbridge_gate_ctl.sv
module hbridge_gate_ctl
  import hbg_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int DEAD_CYC    = 50,
  parameter int WAKE_CYC    = 100000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sleep_n_i,
  input  logic dir_i,
  input  logic en_i,
  input  logic mode1_i,
  input  logic mode2_i,
  input  logic zero_i,
  input  logic force_off_i,
  output logic gate_ah_o,
  output logic gate_al_o,
  output logic gate_bh_o,
  output logic gate_bl_o
);
  logic [CTL_W-1:0] ctl_raw, ctl_s;
  bridge_t          tgt;
  logic             ready, zero_hold;
  logic [1:0]       leg_hi, leg_lo, leg_done;
  leg_t             leg_tgt [2];

  assign ctl_raw = {zero_i, mode2_i, mode1_i, en_i, dir_i, sleep_n_i};

  hbg_sync #(.WIDTH(CTL_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(ctl_raw), .q_o(ctl_s)
  );

  hbg_cmd #(.WAKE_CYC(WAKE_CYC)) u_cmd (
    .clk(clk), .rst_n(rst_n), .ctl_i(ctl_s), .tgt_o(tgt),
    .ready_o(ready), .zero_hold_o(zero_hold)
  );

  assign leg_tgt[0] = tgt.a;
  assign leg_tgt[1] = tgt.b;

  for (genvar g = 0; g < 2; g++) begin : g_leg
    hbg_leg #(.DEAD_CYC(DEAD_CYC)) u_leg (
      .clk(clk), .rst_n(rst_n), .tgt_i(leg_tgt[g]), .force_off_i(force_off_i),
      .gate_hi_o(leg_hi[g]), .gate_lo_o(leg_lo[g]), .dead_done_o(leg_done[g])
    );
  end

  assign gate_ah_o = leg_hi[0];
  assign gate_al_o = leg_lo[0];
  assign gate_bh_o = leg_hi[1];
  assign gate_bl_o = leg_lo[1];
endmodule

// File: rtl/hbg_chk.sv
module hbg_chk #(
  parameter int SYNC_STAGES = 2,
  parameter int DEAD_CYC    = 50
) (
  input logic clk,
  input logic rst_n,
  input logic sleep_n_i,
  input logic force_off_i,
  input logic gate_ah_o,
  input logic gate_al_o,
  input logic gate_bh_o,
  input logic gate_bl_o
);
  logic [31:0] open_a, open_b, asleep;
  logic        any_on;

  assign any_on = gate_ah_o | gate_al_o | gate_bh_o | gate_bl_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_a <= '0;
      open_b <= '0;
      asleep <= '0;
    end else begin
      open_a <= (gate_ah_o || gate_al_o) ? '0 : ((open_a == '1) ? open_a : open_a + 1);
      open_b <= (gate_bh_o || gate_bl_o) ? '0 : ((open_b == '1) ? open_b : open_b + 1);
      asleep <= sleep_n_i ? '0 : ((asleep == '1) ? asleep : asleep + 1);
    end
  end

  // R7
  leg_a_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(gate_ah_o && gate_al_o));
  // R7
  leg_b_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(gate_bh_o && gate_bl_o));
  // R9
  force_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    force_off_i |-> !any_on);
  // R6
  dead_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(gate_ah_o) || $rose(gate_al_o)) |-> (open_a >= 32'(DEAD_CYC)));
  // R6
  dead_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(gate_bh_o) || $rose(gate_bl_o)) |-> (open_b >= 32'(DEAD_CYC)));
  // R1
  sleep_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (asleep >= 32'(SYNC_STAGES + 1)) |-> !any_on);
endmodule

bind hbridge_gate_ctl hbg_chk #(.SYNC_STAGES(SYNC_STAGES), .DEAD_CYC(DEAD_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .sleep_n_i(sleep_n_i), .force_off_i(force_off_i),
  .gate_ah_o(gate_ah_o), .gate_al_o(gate_al_o),
  .gate_bh_o(gate_bh_o), .gate_bl_o(gate_bl_o)
);

// File: tb/hbridge_gate_ctl_test.sv
module hbridge_gate_ctl_test;
  localparam int CLK_PERIOD = 10;
  localparam int SYNC = 2;
  localparam int DEAD = 3;
  localparam int WAKE = 20;

  logic clk = 0, rst_n = 0, sleep_n = 1, dir = 0, en = 0;
  logic m1 = 0, m2 = 0, zero = 0, force_off = 0;
  wire  ah, al, bh, bl;

  always #(CLK_PERIOD/2) clk = ~clk;

  hbridge_gate_ctl #(.SYNC_STAGES(SYNC), .DEAD_CYC(DEAD), .WAKE_CYC(WAKE)) uut (
    .clk(clk), .rst_n(rst_n), .sleep_n_i(sleep_n), .dir_i(dir), .en_i(en),
    .mode1_i(m1), .mode2_i(m2), .zero_i(zero), .force_off_i(force_off),
    .gate_ah_o(ah), .gate_al_o(al), .gate_bh_o(bh), .gate_bl_o(bl)
  );

  int    errors = 0, checks = 0;
  string phase = "R10";
  bit    done = 0;

  // reference model state: leg code 0 open, 1 high side, 2 low side
  logic [5:0] m_pipe [SYNC];
  int   m_wait, m_cur[2], m_cnt[2], m_tgt[2];
  bit   m_hold, s_sl, s_dir, s_en, s_m1, s_m2, s_zero, rdy;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < SYNC; i++) m_pipe[i] = '0;
      m_wait = WAKE; m_hold = 0;
      for (int l = 0; l < 2; l++) begin m_cur[l] = 0; m_cnt[l] = DEAD - 1; end
    end else begin
      {s_zero, s_m2, s_m1, s_en, s_dir, s_sl} = m_pipe[SYNC-1];
      rdy = s_sl && (m_wait == 0);
      if (!rdy) begin m_tgt[0] = 0; m_tgt[1] = 0; end
      else if (s_en) begin m_tgt[0] = s_dir ? 1 : 2; m_tgt[1] = s_dir ? 2 : 1; end
      else if (!s_m1) begin
        if (m_hold || s_zero) begin m_tgt[0] = 0; m_tgt[1] = 0; end
        else begin m_tgt[0] = s_dir ? 2 : 1; m_tgt[1] = s_dir ? 1 : 2; end
      end else begin m_tgt[0] = s_m2 ? 1 : 2; m_tgt[1] = m_tgt[0]; end
      for (int l = 0; l < 2; l++) begin
        if (force_off) begin m_cur[l] = 0; m_cnt[l] = DEAD - 1; end
        else if (m_cur[l] != 0 && m_cur[l] != m_tgt[l]) begin m_cur[l] = 0; m_cnt[l] = DEAD - 1; end
        else if (m_cur[l] == 0) begin
          if (m_cnt[l] > 0) m_cnt[l]--;
          else if (m_tgt[l] != 0) m_cur[l] = m_tgt[l];
        end
      end
      if (!s_sl) m_wait = WAKE; else if (m_wait > 0) m_wait--;
      if (s_en) m_hold = 0; else if (rdy && !s_m1 && s_zero) m_hold = 1;
      for (int i = SYNC - 1; i > 0; i--) m_pipe[i] = m_pipe[i-1];
      m_pipe[0] = {zero, m2, m1, en, dir, sleep_n};
    end
  end

  function automatic logic [3:0] model_gates();
    logic [3:0] g;
    g = {m_cur[0] == 1, m_cur[0] == 2, m_cur[1] == 1, m_cur[1] == 2};
    return force_off ? 4'b0000 : g;
  endfunction

  // per-cycle comparison against the model, plus leg exclusivity (R7)
  always @(posedge clk) begin
    #8;
    if (!done) begin
      checks++;
      if ({ah, al, bh, bl} !== model_gates()) begin
        errors++;
        $display("FAIL %s cycle compare: actual=%b expected=%b", phase, {ah, al, bh, bl}, model_gates());
      end
      checks++;
      if ((ah && al) || (bh && bl)) begin
        errors++;
        $display("FAIL R7 leg overlap: actual=%b expected=no leg with both gates", {ah, al, bh, bl});
      end
    end
  end

  task automatic check(input string req, input logic [3:0] exp);
    checks++;
    if ({ah, al, bh, bl} !== exp) begin
      errors++;
      $display("FAIL %s gates: actual=%b expected=%b", req, {ah, al, bh, bl}, exp);
    end
  endtask

  task automatic edge_drive();
    @(posedge clk); #2;
  endtask

  task automatic settle(input int n);
    repeat (n) @(posedge clk);
    #6;
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      summary();
      $finish;
    end
  end

  initial begin
    // R10: reset state
    repeat (2) @(posedge clk); #6;
    check("R10", 4'b0000);
    edge_drive(); rst_n = 1; en = 1; dir = 1;
    phase = "R8";
    settle(10); check("R10", 4'b0000);
    check("R8", 4'b0000);
    settle(25); phase = "R2"; check("R2", 4'b1001);

    // R6: both legs reverse through the dead interval
    edge_drive(); dir = 0; phase = "R6";
    settle(3); check("R6", 4'b0000);
    settle(2); check("R6", 4'b0000);
    settle(1); check("R6", 4'b0110);

    // R2: mode bits ignored while driving
    phase = "R2";
    edge_drive(); m1 = 1; m2 = 1; settle(10); check("R2", 4'b0110);
    edge_drive(); m2 = 0; settle(10); check("R2", 4'b0110);

    // R4: slow decay, direction ignored
    phase = "R4";
    edge_drive(); en = 0; settle(10); check("R4", 4'b0101);
    edge_drive(); dir = 1; settle(10); check("R4", 4'b0101);
    edge_drive(); m2 = 1; settle(10); check("R4", 4'b1010);
    edge_drive(); dir = 0; settle(10); check("R4", 4'b1010);

    // R3: fast decay
    phase = "R3";
    edge_drive(); m1 = 0; settle(10); check("R3", 4'b1001);
    edge_drive(); dir = 1; settle(10); check("R3", 4'b0110);

    // R5: zero flag release and hold
    phase = "R5";
    edge_drive(); zero = 1; settle(3); check("R5", 4'b0000);
    edge_drive(); zero = 0; settle(10); check("R5", 4'b0000);
    edge_drive(); m1 = 1; m2 = 0; settle(10); check("R5", 4'b0101);
    edge_drive(); m1 = 0; settle(10); check("R5", 4'b0000);
    edge_drive(); en = 1; settle(10); check("R5", 4'b1001);
    edge_drive(); en = 0; settle(10); check("R5", 4'b0110);

    // PWM on enable with slow decay off-phase, then 100% enable
    phase = "R6";
    edge_drive(); m1 = 1; m2 = 0;
    for (int k = 0; k < 24; k++) begin
      edge_drive(); en = ~en;
      repeat (7) @(posedge clk);
    end
    phase = "R2";
    edge_drive(); en = 1; settle(300); check("R2", 4'b1001);

    // R9: force-off acts at once, release through dead interval
    phase = "R9";
    edge_drive(); force_off = 1; #4; check("R9", 4'b0000);
    edge_drive(); force_off = 0;
    settle(2); check("R9", 4'b0000);
    settle(1); check("R9", 4'b1001);

    // R1: sleep opens the bridge whatever the other inputs do
    phase = "R1";
    edge_drive(); sleep_n = 0; settle(3); check("R1", 4'b0000);
    edge_drive(); en = 0; m1 = 1; m2 = 1; dir = 0; settle(5); check("R1", 4'b0000);
    edge_drive(); en = 1; dir = 1; settle(5); check("R1", 4'b0000);

    // R8: wake-up interval after sleep rises
    phase = "R8";
    edge_drive(); sleep_n = 1;
    settle(WAKE + 2); check("R8", 4'b0000);
    settle(1); check("R8", 4'b1001);

    settle(3);
    done = 1;
    summary();
    $finish;
  end
endmodule